// File: doc/BRIEF.md
# Down-Counting Interval Timer

This block is a word-addressed interval timer with a single level interrupt. Software writes a load value and then sets the enable bit. The count takes the load value and then drops by one on every tick. A tick is the input clock divided by two to the power of a prescale parameter that is fixed at elaboration. The block has no compare register. The only timed event is a tick that arrives while the count sits at zero, so software sets a timeout by choosing the load value. A load of L gives L+1 ticks from start to the event.

A mode bit selects what happens at the event:
- **One-shot:** the timer stops at zero and clears its own enable bit.
- **Periodic:** the timer reloads and keeps running.

Every event sets a pending flag. The interrupt output shows that flag unless the interrupt-disable bit in the control word is set. Software clears the flag by writing 1 to the clear register. Software can also overwrite the running count directly.

Top module: `intv_timer`

## Requirements
- R1: After synchronous reset every register reads zero and `irq` is low.
- R2: While enabled, the count drops by one on each tick, and a tick occurs once every 2^PRESCALE_LOG2 clocks from reset.
- R3: A control write that sets enable bit 0 while the timer is stopped copies the load register into the count register on that edge.
- R4: A tick while enabled with the count at zero is a zero event. In one-shot mode (control bit 1 = 0), the event clears the enable bit and the count stays at zero.
- R5: In periodic mode (control bit 1 = 1), a zero event reloads the count from the load register and the enable bit stays set.
- R6: A zero event sets the pending flag (status bit 0) even when interrupt-disable (control bit 2) is 1. `irq` is high exactly when the flag is set and control bit 2 is 0.
- R7: Writing the clear register with bit 0 = 1 clears the pending flag, and writing it with bit 0 = 0 has no effect. When a zero event and a clear write fall on the same edge, the flag ends up set.
- R8: A write to the count register replaces the count. Clearing the enable bit freezes the count at its present value.
- R9: Register map by byte address:
  - 0x00: control (bit 0 enable, bit 1 mode, bit 2 interrupt-disable)
  - 0x04: load
  - 0x08: count
  - 0x0C: status
  - 0x10: clear, which always reads zero

  Other addresses, and addresses whose two low bits are not zero, read zero and ignore writes. A cycle with a control or count write takes no counting step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the following about the bus:
- A write lasts exactly one cycle.
- Address and data are stable around the clock edge.
- Reset is held for at least one edge before any access.

The stimulus keeps to these rules. It drives each access one time unit after a rising edge, drops the write strobe after a single edge, and releases reset only after several cycles.

The behavioural model in the bench works from the same assumptions. It covers back-to-back clear writes that collide with zero events every other clock. It also covers a load of zero, which in periodic mode makes an event on every tick.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;

    localparam int CTRL_W = 3;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_LOAD   = 3'd1,
        SEL_COUNT  = 3'd2,
        SEL_STATUS = 3'd3,
        SEL_CLEAR  = 3'd4,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic irq_dis;
        logic periodic;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic ctrl;
        logic load;
        logic count;
        logic clear;
    } wr_strobe_t;

    function automatic reg_sel_e decode_addr(input logic [4:0] a);
        if (a[1:0] != 2'b00) return SEL_NONE;
        case (a[4:2])
            3'd0:    return SEL_CTRL;
            3'd1:    return SEL_LOAD;
            3'd2:    return SEL_COUNT;
            3'd3:    return SEL_STATUS;
            3'd4:    return SEL_CLEAR;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/intv_tick_div.sv
module intv_tick_div #(
    parameter int PRESCALE_LOG2 = 0
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (PRESCALE_LOG2 == 0) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            logic [PRESCALE_LOG2-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst) div_q <= '0;
                else     div_q <= div_q + 1'b1;
            end
            assign tick = &div_q;
        end
    endgenerate
endmodule

// File: rtl/intv_regs.sv
module intv_regs
    import intv_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic              zero_evt,
    input  logic              oneshot_done,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] load_q,
    output logic              pend_q,
    output wr_strobe_t        wr,
    output logic              start_pulse,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int PAD_CTRL = DATA_W - CTRL_W;

    reg_sel_e sel;

    always_comb begin
        sel      = decode_addr(bus_addr);
        wr.ctrl  = bus_wen && (sel == SEL_CTRL);
        wr.load  = bus_wen && (sel == SEL_LOAD);
        wr.count = bus_wen && (sel == SEL_COUNT);
        wr.clear = bus_wen && (sel == SEL_CLEAR);
        start_pulse = wr.ctrl && bus_wdata[0] && !ctrl_q.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr.ctrl) begin
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end else if (oneshot_done) begin
            ctrl_q.en <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          load_q <= '0;
        else if (wr.load) load_q <= bus_wdata;
    end

    // A new event outranks a clear landing on the same edge.
    always_ff @(posedge clk) begin
        if (rst)                            pend_q <= 1'b0;
        else if (zero_evt)                  pend_q <= 1'b1;
        else if (wr.clear && bus_wdata[0])  pend_q <= 1'b0;
    end

    always_comb begin
        case (sel)
            SEL_CTRL:   bus_rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
            SEL_LOAD:   bus_rdata = load_q;
            SEL_COUNT:  bus_rdata = cnt_q;
            SEL_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, pend_q};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intv_count_core.sv
module intv_count_core
    import intv_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  ctrl_t             ctrl_q,
    input  logic [DATA_W-1:0] load_q,
    input  wr_strobe_t        wr,
    input  logic              start_pulse,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] cnt_q,
    output logic              zero_evt,
    output logic              oneshot_done
);
    logic step;
    logic at_zero;

    always_comb begin
        step         = tick && ctrl_q.en && !wr.ctrl && !wr.count;
        at_zero      = (cnt_q == '0);
        zero_evt     = step && at_zero;
        oneshot_done = zero_evt && !ctrl_q.periodic;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start_pulse) begin
            cnt_q <= load_q;
        end else if (wr.count) begin
            cnt_q <= bus_wdata;
        end else if (step) begin
            if (!at_zero)              cnt_q <= cnt_q - 1'b1;
            else if (ctrl_q.periodic)  cnt_q <= load_q;
        end
    end
endmodule

// File: rtl/intv_timer.sv
module intv_timer
    import intv_timer_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int PRESCALE_LOG2 = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              tick;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] cnt_q;
    logic              pend_q;
    wr_strobe_t        wr;
    logic              start_pulse;
    logic              zero_evt;
    logic              oneshot_done;

    intv_tick_div #(.PRESCALE_LOG2(PRESCALE_LOG2)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    intv_regs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wen      (bus_wen),
        .bus_wdata    (bus_wdata),
        .cnt_q        (cnt_q),
        .zero_evt     (zero_evt),
        .oneshot_done (oneshot_done),
        .ctrl_q       (ctrl_q),
        .load_q       (load_q),
        .pend_q       (pend_q),
        .wr           (wr),
        .start_pulse  (start_pulse),
        .bus_rdata    (bus_rdata)
    );

    intv_count_core #(.DATA_W(DATA_W)) u_core (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .ctrl_q       (ctrl_q),
        .load_q       (load_q),
        .wr           (wr),
        .start_pulse  (start_pulse),
        .bus_wdata    (bus_wdata),
        .cnt_q        (cnt_q),
        .zero_evt     (zero_evt),
        .oneshot_done (oneshot_done)
    );

    assign irq = pend_q && !ctrl_q.irq_dis;
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              en,
    input logic              periodic,
    input logic              irq_dis,
    input logic              wr_ctrl,
    input logic              wr_cnt,
    input logic [DATA_W-1:0] cnt_q,
    input logic              pend_q,
    input logic              zero_evt,
    input logic              irq
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && !pend_q && !en && !irq));

    assert_step_dec_R2: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !wr_ctrl && !wr_cnt && cnt_q != '0)
        |=> cnt_q == $past(cnt_q) - DATA_W'(1));

    assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (zero_evt && !periodic) |=> (!en && cnt_q == '0));

    assert_periodic_keeps_en_R5: assert property (@(posedge clk) disable iff (rst)
        (zero_evt && periodic) |=> en);

    assert_evt_sets_pend_R6: assert property (@(posedge clk) disable iff (rst)
        zero_evt |=> pend_q);

    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
        irq_dis |-> !irq);

    assert_irq_needs_pend_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> pend_q);

    assert_frozen_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr_ctrl && !wr_cnt) |=> $stable(cnt_q));
endmodule

bind intv_timer intv_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .en       (ctrl_q.en),
    .periodic (ctrl_q.periodic),
    .irq_dis  (ctrl_q.irq_dis),
    .wr_ctrl  (wr.ctrl),
    .wr_cnt   (wr.count),
    .cnt_q    (cnt_q),
    .pend_q   (pend_q),
    .zero_evt (zero_evt),
    .irq      (irq)
);

// File: tb/sim_intv_timer.sv
module sim_intv_timer;
    localparam int DW = 32;
    localparam int PL = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    bus_addr = '0;
    logic          bus_wen = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    intv_timer #(.DATA_W(DW), .PRESCALE_LOG2(PL)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    // Behavioural reference model
    bit          m_en, m_per, m_dis, m_pend;
    logic [31:0] m_load, m_cnt;
    int          m_cyc;

    function automatic logic [31:0] m_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 32'd0;
        case (a)
            5'h00:   return {29'd0, m_dis, m_per, m_en};
            5'h04:   return m_load;
            5'h08:   return m_cnt;
            5'h0C:   return {31'd0, m_pend};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_per = 0; m_dis = 0; m_pend = 0;
            m_load = 0; m_cnt = 0; m_cyc = 0;
        end else begin
            bit tk, wc, wk, ev;
            tk = ((m_cyc % (1 << PL)) == (1 << PL) - 1);
            m_cyc++;
            wc = bus_wen && bus_addr == 5'h00;
            wk = bus_wen && bus_addr == 5'h08;
            ev = 0;
            if (wc) begin
                if (bus_wdata[0] && !m_en) m_cnt = m_load;
                {m_dis, m_per, m_en} = bus_wdata[2:0];
            end else if (wk) begin
                m_cnt = bus_wdata;
            end else if (tk && m_en) begin
                if (m_cnt != 0) m_cnt = m_cnt - 1;
                else begin
                    ev = 1;
                    if (m_per) m_cnt = m_load;
                    else m_en = 0;
                end
            end
            if (bus_wen && bus_addr == 5'h04) m_load = bus_wdata;
            if (ev) m_pend = 1;
            else if (bus_wen && bus_addr == 5'h10 && bus_wdata[0]) m_pend = 0;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (irq !== (m_pend && !m_dis) || bus_rdata !== m_read(bus_addr)) begin
                fails++;
                $display("FAIL R2,R5,R6,R7 per-cycle: irq=%0b rdata=%h expected irq=%0b rdata=%h",
                         irq, bus_rdata, m_pend && !m_dis, m_read(bus_addr));
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(posedge clk); #1;
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        @(negedge clk);
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
        @(posedge clk); #1;
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
        end
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_up;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] frozen;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        rd(5'h00, 32'd0, "R1 ctrl");
        rd(5'h04, 32'd0, "R1 load");
        rd(5'h08, 32'd0, "R1 count");
        rd(5'h0C, 32'd0, "R1 status");
        chk_irq(1'b0, "R1");
        // R3 and R4: one-shot run
        wr(5'h04, 32'd3);
        wr(5'h00, 32'h1);
        rd(5'h08, 32'd3, "R3 reload on start");
        idle(12);
        rd(5'h00, 32'd0, "R4 enable cleared");
        rd(5'h08, 32'd0, "R4 holds zero");
        rd(5'h0C, 32'd1, "R6 pending set");
        chk_irq(1'b1, "R6 irq");
        // R7: clear semantics
        wr(5'h10, 32'd0);
        rd(5'h0C, 32'd1, "R7 zero write ignored");
        wr(5'h10, 32'd1);
        rd(5'h0C, 32'd0, "R7 cleared");
        chk_irq(1'b0, "R7 irq low");
        // R6: masked event still sets pending
        wr(5'h00, 32'h5);
        idle(12);
        rd(5'h0C, 32'd1, "R6 masked pending");
        chk_irq(1'b0, "R6 masked irq");
        wr(5'h10, 32'd1);
        // R5: periodic mode
        wr(5'h04, 32'd2);
        wr(5'h00, 32'h3);
        idle(40);
        rd(5'h00, 32'h3, "R5 still enabled");
        rd(5'h0C, 32'd1, "R5 events raised");
        // R8: freeze and overwrite
        wr(5'h00, 32'h2);
        bus_addr = 5'h08;
        @(negedge clk);
        frozen = bus_rdata;
        @(posedge clk); #1;
        idle(6);
        rd(5'h08, frozen, "R8 frozen");
        wr(5'h08, 32'd7);
        rd(5'h08, 32'd7, "R8 overwrite");
        // R9: map edges
        rd(5'h10, 32'd0, "R9 clear reads zero");
        rd(5'h14, 32'd0, "R9 unmapped");
        wr(5'h05, 32'hFFFF);
        rd(5'h04, 32'd2, "R9 misaligned write ignored");
        // R7: set wins vs clear, load zero periodic
        wr(5'h04, 32'd0);
        wr(5'h00, 32'h3);
        for (int i = 0; i < 8; i++) wr(5'h10, 32'd1);
        rd(5'h0C, {31'd0, m_pend}, "R7 collision");
        // R2: large count decrements under prescale
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h00, 32'h0);
        wr(5'h00, 32'h1);
        idle(20);
        rd(5'h08, m_cnt, "R2 decrement");
        finish_up();
    end
endmodule